// File: doc/BRIEF.md
# Self-Testing Adder Wrapper

This block wraps a combinational adder that the surrounding datapath uses only on some cycles. On cycles when no functional request is present, a small sequencer can take over the adder's operand inputs and drive it with stored test vectors. Each result is compared against an expected sum that is fixed when the block is built. A mismatch sets a diagnostic error flag, so a stuck or broken adder is caught between functional uses.

An external timer decides when a test should run and pulses `start`. A diagnostic enable gates the whole mechanism. A test runs `NVEC` vectors, one per cycle, and reports `busy`, a one-cycle `done` and a sticky `err`. A functional request always wins: the operand multiplexers return to the functional path in the cycle the request appears, and the test is dropped without any error. An injection input inverts the outcome of the comparison, so software can prove that the checker itself can raise `err`.

Top module: `st_adder_selftest`

## Requirements
- R1: `fn_sum` equals the zero-extended sum `fn_a + fn_b` (WIDTH+1 bits, carry in the top bit) in the same cycle, whenever no test is running or `fn_valid` is high.
- R2: A `start` pulse is taken only while idle and with `diag_en` high. `busy` is high from the next clock edge onwards.
- R3: An uninterrupted test keeps `busy` high for exactly NVEC cycles. In the cycle after the last vector, `busy` is low and `done` is high for exactly one cycle.
- R4: Each vector's adder result is compared with its stored expected sum. On a correct adder with `inject` low, a full test leaves `err` low.
- R5: `err` stays set while idle, until reset or until the next accepted `start`, which clears it.
- R6: With `inject` high during a test, the comparison outcome is inverted, so a correct adder sets `err` by the time `done` pulses.
- R7: `fn_valid` high during a test switches the adder back to `fn_a`/`fn_b` in that same cycle. At the next edge the test ends with no `done` pulse and `err` unchanged, even if `inject` is high.
- R8: `diag_en` low during a test ends it at the next edge with no `done` pulse and no error. `start` with `diag_en` low leaves `busy` low.
- R9: A `start` pulse while `busy` is high is ignored: the running test ends on its original schedule.
- R10: After reset, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_en | input | 1 | Enables the self-test mechanism |
| start | input | 1 | Pulse requesting one test sequence |
| inject | input | 1 | Inverts the comparison outcome to exercise the checker |
| fn_valid | input | 1 | Functional use of the adder this cycle |
| fn_a | input | WIDTH | Functional operand A |
| fn_b | input | WIDTH | Functional operand B |
| fn_sum | output | WIDTH+1 | Adder result with carry |
| busy | output | 1 | Test sequence in progress |
| done | output | 1 | One-cycle pulse after the last vector |
| err | output | 1 | Sticky diagnostic mismatch flag |

## Verification
On every cycle, the assertions check the following:
- the functional path through the operand multiplexers whenever no test holds the adder;
- the single-cycle width of `done`;
- that `err` stays put while idle;
- that an abort by `fn_valid` or `diag_en` ends the test quietly.

Some properties only the bench scenarios can show. These are that a run lasts exactly NVEC cycles, that injection turns a clean run into an error, that a fresh start clears a stale error, and that a second start during a run changes nothing.

// File: rtl/st_pkg.sv
package st_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_state_e;
endpackage

// File: rtl/st_vec_rom.sv
module st_vec_rom #(
    parameter int WIDTH = 16,
    parameter int NVEC  = 4,
    parameter int IDXW  = 2
) (
    input  logic [IDXW-1:0]  idx,
    output logic [WIDTH-1:0] tv_a,
    output logic [WIDTH-1:0] tv_b,
    output logic [WIDTH:0]   tv_exp
);
    localparam int DEPTH = 2 ** IDXW;

    // operand A pattern, chosen to toggle every bit and the carry chain
    function automatic logic [WIDTH-1:0] pat_a(int i);
        logic [WIDTH-1:0] v;
        for (int j = 0; j < WIDTH; j++) begin
            case (i % 4)
                0:       v[j] = 1'b1;
                1:       v[j] = (j % 2 == 0);
                2:       v[j] = (j % 2 == 1);
                default: v[j] = (j == (i % WIDTH));
            endcase
        end
        return v;
    endfunction

    function automatic logic [WIDTH-1:0] pat_b(int i);
        logic [WIDTH-1:0] v;
        for (int j = 0; j < WIDTH; j++) begin
            case (i % 4)
                0:       v[j] = (j == 0);
                1:       v[j] = (j % 2 == 1);
                2:       v[j] = (j % 2 == 1);
                default: v[j] = 1'b1;
            endcase
        end
        return v;
    endfunction

    logic [WIDTH-1:0] rom_a   [DEPTH];
    logic [WIDTH-1:0] rom_b   [DEPTH];
    logic [WIDTH:0]   rom_exp [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        if (g < NVEC) begin : g_used
            assign rom_a[g]   = pat_a(g);
            assign rom_b[g]   = pat_b(g);
            assign rom_exp[g] = {1'b0, pat_a(g)} + {1'b0, pat_b(g)};
        end else begin : g_pad
            assign rom_a[g]   = '0;
            assign rom_b[g]   = '0;
            assign rom_exp[g] = '0;
        end
    end

    assign tv_a   = rom_a[idx];
    assign tv_b   = rom_b[idx];
    assign tv_exp = rom_exp[idx];
endmodule

// File: rtl/st_adder.sv
module st_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH:0]   sum
);
    assign sum = {1'b0, op_a} + {1'b0, op_b};
endmodule

// File: rtl/st_cmp.sv
module st_cmp #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH:0] res,
    input  logic [WIDTH:0] expv,
    input  logic           flip,
    output logic           mismatch
);
    assign mismatch = (res != expv) ^ flip;
endmodule

// File: rtl/st_adder_selftest.sv
module st_adder_selftest #(
    parameter int WIDTH = 16,
    parameter int NVEC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             diag_en,
    input  logic             start,
    input  logic             inject,
    input  logic             fn_valid,
    input  logic [WIDTH-1:0] fn_a,
    input  logic [WIDTH-1:0] fn_b,
    output logic [WIDTH:0]   fn_sum,
    output logic             busy,
    output logic             done,
    output logic             err
);
    import st_pkg::*;

    localparam int IDXW = (NVEC > 1) ? $clog2(NVEC) : 1;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NVEC - 1);

    typedef struct packed {
        st_state_e       state;
        logic [IDXW-1:0] idx;
        logic            done;
        logic            err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [WIDTH-1:0] tv_a, tv_b;
    logic [WIDTH:0]   tv_exp;
    logic [WIDTH-1:0] mux_a, mux_b;
    logic [WIDTH:0]   add_res;
    logic             use_test;
    logic             mismatch;

    st_vec_rom #(.WIDTH(WIDTH), .NVEC(NVEC), .IDXW(IDXW)) u_rom (
        .idx    (seq_q.idx),
        .tv_a   (tv_a),
        .tv_b   (tv_b),
        .tv_exp (tv_exp)
    );

    // test owns the adder only when running, enabled and not needed functionally
    assign use_test = (seq_q.state == ST_RUN) && diag_en && !fn_valid;
    assign mux_a    = use_test ? tv_a : fn_a;
    assign mux_b    = use_test ? tv_b : fn_b;

    st_adder #(.WIDTH(WIDTH)) u_add (
        .op_a (mux_a),
        .op_b (mux_b),
        .sum  (add_res)
    );

    st_cmp #(.WIDTH(WIDTH)) u_cmp (
        .res      (add_res),
        .expv     (tv_exp),
        .flip     (inject),
        .mismatch (mismatch)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (start && diag_en) begin
                    seq_d.state = ST_RUN;
                    seq_d.idx   = '0;
                    seq_d.err   = 1'b0;
                end
            end
            ST_RUN: begin
                if (!use_test) begin
                    seq_d.state = ST_IDLE;
                end else begin
                    if (mismatch) begin
                        seq_d.err = 1'b1;
                    end
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, idx: '0, done: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fn_sum = add_res;
    assign busy   = (seq_q.state == ST_RUN);
    assign done   = seq_q.done;
    assign err    = seq_q.err;
endmodule

// File: rtl/st_adder_selftest_chk.sv
module st_adder_selftest_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             diag_en,
    input logic             start,
    input logic             fn_valid,
    input logic [WIDTH-1:0] fn_a,
    input logic [WIDTH-1:0] fn_b,
    input logic [WIDTH:0]   fn_sum,
    input logic             busy,
    input logic             done,
    input logic             err
);
    p_func_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || fn_valid) |-> fn_sum == ({1'b0, fn_a} + {1'b0, fn_b}));

    p_start_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && diag_en) |=> (busy && !err));

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && diag_en)) |=> $stable(err));

    p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fn_valid) |=> (!busy && !done && $stable(err)));

    p_diag_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !diag_en) |=> (!busy && !done && $stable(err)));
endmodule

bind st_adder_selftest st_adder_selftest_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .diag_en  (diag_en),
    .start    (start),
    .fn_valid (fn_valid),
    .fn_a     (fn_a),
    .fn_b     (fn_b),
    .fn_sum   (fn_sum),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/tb_st_adder_selftest.sv
module tb_st_adder_selftest;
    localparam int WIDTH = 16;
    localparam int NVEC  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             diag_en = 1'b0;
    logic             start = 1'b0;
    logic             inject = 1'b0;
    logic             fn_valid = 1'b0;
    logic [WIDTH-1:0] fn_a = '0;
    logic [WIDTH-1:0] fn_b = '0;
    logic [WIDTH:0]   fn_sum;
    logic             busy, done, err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    st_adder_selftest #(.WIDTH(WIDTH), .NVEC(NVEC)) dut (
        .clk(clk), .rst_n(rst_n), .diag_en(diag_en), .start(start),
        .inject(inject), .fn_valid(fn_valid), .fn_a(fn_a), .fn_b(fn_b),
        .fn_sum(fn_sum), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    // counts busy samples after start, leaves sampling at the done cycle
    task automatic run_to_end(output int cnt);
        cnt = 0;
        while (busy && cnt < 50) begin
            cnt++;
            tick();
        end
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R10 busy", busy, 0);
        chk(done == 1'b0, "R10 done", done, 0);
        chk(err == 1'b0, "R10 err", err, 0);
    endtask

    task automatic t_func();
        logic [WIDTH:0] e;
        fn_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            fn_a = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h1234 : (k == 2) ? 16'h8000 : 16'h0000;
            fn_b = (k == 0) ? 16'h0001 : (k == 1) ? 16'h4321 : (k == 2) ? 16'h8000 : 16'h0000;
            #1;
            e = {1'b0, fn_a} + {1'b0, fn_b};
            chk(fn_sum == e, "R1 functional sum", int'(fn_sum), int'(e));
        end
        fn_valid = 1'b0;
        fn_a = 16'h00F0; fn_b = 16'h0F00;
        #1;
        chk(fn_sum == 17'h00FF0, "R1 idle sum", int'(fn_sum), 'hFF0);
        tick();
    endtask

    task automatic t_full();
        int cnt;
        pulse_start();
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        run_to_end(cnt);
        chk(cnt == NVEC, "R3 busy length", cnt, NVEC);
        chk(done == 1'b1, "R3 done pulse", done, 1);
        chk(err == 1'b0, "R4 clean run", err, 0);
        tick();
        chk(done == 1'b0, "R3 done one cycle", done, 0);
    endtask

    task automatic t_inject();
        int cnt;
        inject = 1'b1;
        pulse_start();
        run_to_end(cnt);
        inject = 1'b0;
        chk(err == 1'b1, "R6 injected error", err, 1);
        tick(); tick(); tick();
        chk(err == 1'b1, "R5 err held", err, 1);
        pulse_start();
        chk(err == 1'b0, "R5 err cleared by start", err, 0);
        run_to_end(cnt);
        chk(err == 1'b0, "R5 clean rerun", err, 0);
        tick();
    endtask

    task automatic t_abort();
        pulse_start();
        tick();
        chk(busy == 1'b1, "R7 running", busy, 1);
        fn_a = 16'hABCD; fn_b = 16'h1111; fn_valid = 1'b1; inject = 1'b1;
        #1;
        chk(fn_sum == 17'h0BCDE, "R7 same-cycle functional", int'(fn_sum), 'hBCDE);
        tick();
        fn_valid = 1'b0; inject = 1'b0;
        chk(busy == 1'b0, "R7 aborted", busy, 1'b0);
        chk(done == 1'b0, "R7 no done", done, 0);
        chk(err == 1'b0, "R7 no err", err, 0);
        tick();
    endtask

    task automatic t_diag();
        diag_en = 1'b0;
        pulse_start();
        chk(busy == 1'b0, "R8 start ignored when disabled", busy, 0);
        diag_en = 1'b1;
        pulse_start();
        diag_en = 1'b0;
        tick();
        chk(busy == 1'b0, "R8 disable aborts", busy, 0);
        chk(done == 1'b0, "R8 no done", done, 0);
        chk(err == 1'b0, "R8 no err", err, 0);
        diag_en = 1'b1;
        tick();
    endtask

    task automatic t_restart();
        int cnt;
        pulse_start();
        tick();
        pulse_start();
        run_to_end(cnt);
        chk(cnt == NVEC - 2, "R9 start while busy ignored", cnt + 2, NVEC);
        chk(done == 1'b1, "R9 done on schedule", done, 1);
        tick();
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        diag_en = 1'b1;
        tick();
        t_reset();
        t_func();
        t_full();
        t_inject();
        t_abort();
        t_diag();
        t_restart();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule